// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Insertion Multiplexer

This block builds timeslot 16 of an outgoing 2.048 Mb/s E1 bit stream. It sits on the transmit path between a serial PCM source and the line side. It sees one bit per enabled cycle, together with the frame, timeslot and bit position of that bit inside the 16-frame multiframe. Every timeslot other than 16 passes straight through. Inside timeslot 16 each four-bit signaling nibble is taken from one of three places: the PCM stream, a separate serial signaling stream, or a per-channel transmit signaling register. In frame 0 a fixed alignment pattern is built, and the alarm and spare bits come from registers.

Two control bits govern the choice. The insertion enable replaces the stream signaling with the serial signaling input. The register-source select turns on per-channel sourcing through a blocking mask, and it forces the frame-0 slot-16 octet to be built from registers. All register and control inputs are captured once, at the first bit of each multiframe, so a mid-multiframe write never splits a multiframe into two configurations.

Top module: `e1cas_ins_mux`

## Requirements
- R1: While `rst_n` is low, `tx_out` is 0, and the captured configuration is cleared to pass-through (`hw_ins_en` = 0, `blk_fsel` = 0).
- R2: For a bit whose `ts_idx` is not 16, `tx_out` equals that bit's `pcm_in` after the next rising edge where `bit_en` is 1.
- R3: `tx_out` changes only on a rising edge where `bit_en` is 1.
- R4: With captured `blk_fsel` = 0 and `hw_ins_en` = 0, every timeslot-16 bit in all frames is taken from `pcm_in`.
- R5: With captured `blk_fsel` = 0 and `hw_ins_en` = 1, every timeslot-16 bit in all frames, frame 0 included, is taken from `sig_in`.
- R6: With captured `blk_fsel` = 1, timeslot 16 of frame 0 is sent as 0,0,0,0,`spare_bits[2]`,`mf_alarm`,`spare_bits[1]`,`spare_bits[0]`, with `bit_idx` 0 sent first.
- R7: With captured `blk_fsel` = 1, in frames f = 1..15, `bit_idx` 0..3 of timeslot 16 carry channel f. If `blk_mask[f]` = 1, the bits are `tsig_regs[4f+3]`, `[4f+2]`, `[4f+1]`, `[4f]` in that order (A first).
- R8: With captured `blk_fsel` = 1, in frames f = 1..15, `bit_idx` 4..7 carry channel f+16. The source is chosen by `blk_mask[f+16]` alone, and a register nibble is taken from `tsig_regs[4(f+16)+3 .. 4(f+16)]`, MSB first.
- R9: A timeslot-16 nibble whose mask bit is 0, when `blk_fsel` = 1, is taken from `sig_in` if `hw_ins_en` = 1 and from `pcm_in` otherwise.
- R10: Control and register inputs are captured on the `bit_en` edge of frame 0, timeslot 0, bit 0. Changes made at any other time take effect only from the next multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit is present this cycle |
| frm_idx | input | 4 | Frame number within the multiframe (0..15) |
| ts_idx | input | 5 | Timeslot number within the frame (0..31) |
| bit_idx | input | 3 | Bit number within the timeslot, 0 sent first |
| pcm_in | input | 1 | Serial PCM input bit |
| sig_in | input | 1 | Serial signaling input bit, aligned to `pcm_in` |
| hw_ins_en | input | 1 | Take stream signaling from `sig_in` instead of `pcm_in` |
| blk_fsel | input | 1 | Enable mask-based register sourcing and the frame-0 register octet |
| blk_mask | input | 32 | Per-channel source mask, 1 = register |
| tsig_regs | input | 128 | Per-channel ABCD nibbles, channel c at bits 4c+3..4c (A at 4c+3) |
| mf_alarm | input | 1 | Multiframe remote alarm bit |
| spare_bits | input | 3 | Spare bits of the frame-0 octet |
| tx_out | output | 1 | Serial output bit, one enabled bit behind the input |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a multiframe. To show it has no effect, the output has to keep following the old configuration for the rest of that multiframe and then switch exactly at the next frame-0 boundary. The stimulus runs a full multiframe with pass-through settings and raises the register-source select and a full mask at frame 3. It then compares every timeslot-16 bit against the still-active old configuration, and runs a second multiframe in which the new configuration must appear.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  typedef enum logic [1:0] {
    SRC_PCM = 2'd0,
    SRC_SIG = 2'd1,
    SRC_FIX = 2'd2
  } bit_src_e;
endpackage

// File: rtl/e1cas_snap.sv
module e1cas_snap #(
  parameter int NUM_CH  = 32,
  parameter int NIB_W   = 4,
  parameter int SPARE_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      ins_d,
  input  logic                      fsel_d,
  input  logic [NUM_CH-1:0]         mask_d,
  input  logic [NUM_CH*NIB_W-1:0]   tsig_d,
  input  logic                      alarm_d,
  input  logic [SPARE_W-1:0]        spare_d,
  output logic                      ins_q,
  output logic                      fsel_q,
  output logic [NUM_CH-1:0]         mask_q,
  output logic [NUM_CH*NIB_W-1:0]   tsig_q,
  output logic                      alarm_q,
  output logic [SPARE_W-1:0]        spare_q
);
  logic                    ins_n, fsel_n, alarm_n;
  logic [NUM_CH-1:0]       mask_n;
  logic [NUM_CH*NIB_W-1:0] tsig_n;
  logic [SPARE_W-1:0]      spare_n;

  always_comb begin
    ins_n   = ins_q;
    fsel_n  = fsel_q;
    mask_n  = mask_q;
    tsig_n  = tsig_q;
    alarm_n = alarm_q;
    spare_n = spare_q;
    if (load) begin
      ins_n   = ins_d;
      fsel_n  = fsel_d;
      mask_n  = mask_d;
      tsig_n  = tsig_d;
      alarm_n = alarm_d;
      spare_n = spare_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q   <= 1'b0;
      fsel_q  <= 1'b0;
      mask_q  <= '0;
      tsig_q  <= '0;
      alarm_q <= 1'b0;
      spare_q <= '0;
    end else begin
      ins_q   <= ins_n;
      fsel_q  <= fsel_n;
      mask_q  <= mask_n;
      tsig_q  <= tsig_n;
      alarm_q <= alarm_n;
      spare_q <= spare_n;
    end
  end
endmodule

// File: rtl/e1cas_sel.sv
module e1cas_sel
  import e1cas_pkg::*;
#(
  parameter int FRM_W   = 4,
  parameter int TS_W    = 5,
  parameter int BIT_W   = 3,
  parameter int SIG_TS  = 16,
  parameter int NUM_CH  = 32,
  parameter int NIB_W   = 4,
  parameter int SPARE_W = 3
) (
  input  logic [FRM_W-1:0]          frm_idx,
  input  logic [TS_W-1:0]           ts_idx,
  input  logic [BIT_W-1:0]          bit_idx,
  input  logic                      ins,
  input  logic                      fsel,
  input  logic [NUM_CH-1:0]         mask,
  input  logic [NUM_CH*NIB_W-1:0]   tsig,
  input  logic                      alarm,
  input  logic [SPARE_W-1:0]        spare,
  output bit_src_e                  src,
  output logic                      fix_bit
);
  localparam int OCT_W = 2 * NIB_W;
  localparam int NIB_B = $clog2(NIB_W);
  localparam int CH_W  = FRM_W + 1;
  localparam int IDX_W = CH_W + NIB_B;
  localparam logic [TS_W-1:0] SIG_TS_V = TS_W'(SIG_TS);

  logic [CH_W-1:0]  ch;
  logic [NIB_B-1:0] nib_pos;
  logic [IDX_W-1:0] tsig_idx;
  logic [OCT_W-1:0] f0_word;
  logic             stream_src_sig;

  assign ch       = {bit_idx[BIT_W-1], frm_idx};
  assign nib_pos  = bit_idx[NIB_B-1:0];
  assign tsig_idx = {ch, ~nib_pos};
  assign f0_word  = {{NIB_W{1'b0}}, spare[2], alarm, spare[1], spare[0]};
  assign stream_src_sig = ins;

  always_comb begin
    src     = SRC_PCM;
    fix_bit = 1'b0;
    if (ts_idx == SIG_TS_V) begin
      if (fsel && (frm_idx == '0)) begin
        src     = SRC_FIX;
        fix_bit = f0_word[OCT_W-1-int'(bit_idx)];
      end else if (fsel && mask[ch]) begin
        src     = SRC_FIX;
        fix_bit = tsig[tsig_idx];
      end else if (stream_src_sig) begin
        src = SRC_SIG;
      end
    end
  end
endmodule

// File: rtl/e1cas_out.sv
module e1cas_out
  import e1cas_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_en,
  input  bit_src_e src,
  input  logic     pcm_in,
  input  logic     sig_in,
  input  logic     fix_bit,
  output logic     tx_q
);
  logic tx_n;

  always_comb begin
    tx_n = tx_q;
    if (bit_en) begin
      unique case (src)
        SRC_SIG: tx_n = sig_in;
        SRC_FIX: tx_n = fix_bit;
        default: tx_n = pcm_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_n;
  end
endmodule

// File: rtl/e1cas_ins_mux.sv
module e1cas_ins_mux
  import e1cas_pkg::*;
#(
  parameter int FRM_PER_MF  = 16,
  parameter int TS_PER_FRM  = 32,
  parameter int BITS_PER_TS = 8,
  parameter int SIG_TS      = 16,
  parameter int NIB_W       = 4,
  parameter int NUM_CH      = 2 * FRM_PER_MF,
  parameter int FRM_W       = $clog2(FRM_PER_MF),
  parameter int TS_W        = $clog2(TS_PER_FRM),
  parameter int BIT_W       = $clog2(BITS_PER_TS),
  parameter int SPARE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic [FRM_W-1:0]        frm_idx,
  input  logic [TS_W-1:0]         ts_idx,
  input  logic [BIT_W-1:0]        bit_idx,
  input  logic                    pcm_in,
  input  logic                    sig_in,
  input  logic                    hw_ins_en,
  input  logic                    blk_fsel,
  input  logic [NUM_CH-1:0]       blk_mask,
  input  logic [NUM_CH*NIB_W-1:0] tsig_regs,
  input  logic                    mf_alarm,
  input  logic [SPARE_W-1:0]      spare_bits,
  output logic                    tx_out
);
  logic                    mf_start;
  logic                    snap_ins, snap_fsel, snap_alarm;
  logic [NUM_CH-1:0]       snap_mask;
  logic [NUM_CH*NIB_W-1:0] snap_tsig;
  logic [SPARE_W-1:0]      snap_spare;
  bit_src_e                src;
  logic                    fix_bit;

  assign mf_start = bit_en && (frm_idx == '0) && (ts_idx == '0) && (bit_idx == '0);

  e1cas_snap #(.NUM_CH(NUM_CH), .NIB_W(NIB_W), .SPARE_W(SPARE_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mf_start),
    .ins_d   (hw_ins_en),
    .fsel_d  (blk_fsel),
    .mask_d  (blk_mask),
    .tsig_d  (tsig_regs),
    .alarm_d (mf_alarm),
    .spare_d (spare_bits),
    .ins_q   (snap_ins),
    .fsel_q  (snap_fsel),
    .mask_q  (snap_mask),
    .tsig_q  (snap_tsig),
    .alarm_q (snap_alarm),
    .spare_q (snap_spare)
  );

  e1cas_sel #(
    .FRM_W(FRM_W), .TS_W(TS_W), .BIT_W(BIT_W), .SIG_TS(SIG_TS),
    .NUM_CH(NUM_CH), .NIB_W(NIB_W), .SPARE_W(SPARE_W)
  ) u_sel (
    .frm_idx (frm_idx),
    .ts_idx  (ts_idx),
    .bit_idx (bit_idx),
    .ins     (snap_ins),
    .fsel    (snap_fsel),
    .mask    (snap_mask),
    .tsig    (snap_tsig),
    .alarm   (snap_alarm),
    .spare   (snap_spare),
    .src     (src),
    .fix_bit (fix_bit)
  );

  e1cas_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .src     (src),
    .pcm_in  (pcm_in),
    .sig_in  (sig_in),
    .fix_bit (fix_bit),
    .tx_q    (tx_out)
  );
endmodule

// File: rtl/e1cas_ins_chk.sv
module e1cas_ins_chk #(
  parameter int FRM_W  = 4,
  parameter int TS_W   = 5,
  parameter int BIT_W  = 3,
  parameter int SIG_TS = 16,
  parameter int NIB_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic [FRM_W-1:0] frm_idx,
  input logic [TS_W-1:0]  ts_idx,
  input logic [BIT_W-1:0] bit_idx,
  input logic             pcm_in,
  input logic             sig_in,
  input logic             snap_ins,
  input logic             snap_fsel,
  input logic             tx_out
);
  localparam logic [TS_W-1:0] SIG_TS_V = TS_W'(SIG_TS);
  localparam logic [BIT_W-1:0] NIB_V   = BIT_W'(NIB_W);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_low_R1: assert (tx_out == 1'b0);
  end

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ts_idx != SIG_TS_V) |=> (tx_out == $past(pcm_in)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_out));

  assert_ts16_pcm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ts_idx == SIG_TS_V && !snap_fsel && !snap_ins) |=> (tx_out == $past(pcm_in)));

  assert_ts16_sig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ts_idx == SIG_TS_V && !snap_fsel && snap_ins) |=> (tx_out == $past(sig_in)));

  assert_f0_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ts_idx == SIG_TS_V && snap_fsel && frm_idx == '0 && bit_idx < NIB_V)
      |=> (tx_out == 1'b0));
endmodule

bind e1cas_ins_mux e1cas_ins_chk #(
  .FRM_W(FRM_W), .TS_W(TS_W), .BIT_W(BIT_W), .SIG_TS(SIG_TS), .NIB_W(NIB_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .frm_idx   (frm_idx),
  .ts_idx    (ts_idx),
  .bit_idx   (bit_idx),
  .pcm_in    (pcm_in),
  .sig_in    (sig_in),
  .snap_ins  (snap_ins),
  .snap_fsel (snap_fsel),
  .tx_out    (tx_out)
);

// File: tb/sim_e1cas_ins_mux.sv
module sim_e1cas_ins_mux;
  logic         clk;
  logic         rst_n;
  logic         bit_en;
  logic [3:0]   frm_idx;
  logic [4:0]   ts_idx;
  logic [2:0]   bit_idx;
  logic         pcm_in, sig_in;
  logic         hw_ins_en, blk_fsel, mf_alarm;
  logic [31:0]  blk_mask;
  logic [127:0] tsig_regs;
  logic [2:0]   spare_bits;
  logic         tx_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  // configuration in force inside the DUT, as the bench models it
  logic         a_ins, a_fsel, a_alarm;
  logic [31:0]  a_mask;
  logic [127:0] a_tsig;
  logic [2:0]   a_spare;

  // {ins, fsel, mask[31:0], alarm, spare[2:0], tseed[7:0]}
  localparam logic [45:0] ROWS [6] = '{
    {1'b0, 1'b0, 32'h0000_0000, 1'b0, 3'b000, 8'h11},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 3'b111, 8'h23},
    {1'b0, 1'b1, 32'hAAAA_5555, 1'b1, 3'b101, 8'h35},
    {1'b1, 1'b1, 32'h0F0F_F0F0, 1'b0, 3'b010, 8'h47},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 3'b111, 8'h59},
    {1'b0, 1'b1, 32'h0000_0000, 1'b0, 3'b000, 8'h6B}
  };

  e1cas_ins_mux u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frm_idx(frm_idx),
    .ts_idx(ts_idx), .bit_idx(bit_idx), .pcm_in(pcm_in), .sig_in(sig_in),
    .hw_ins_en(hw_ins_en), .blk_fsel(blk_fsel), .blk_mask(blk_mask),
    .tsig_regs(tsig_regs), .mf_alarm(mf_alarm), .spare_bits(spare_bits),
    .tx_out(tx_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [127:0] make_tsig(input logic [7:0] seed);
    logic [127:0] v;
    for (int c = 0; c < 32; c++) v[c*4 +: 4] = 4'(c * 7 + seed) ^ seed[7:4];
    return v;
  endfunction

  // expected bit and requirement tag, written from the requirements
  function automatic logic model(input int f, input int t, input int b,
                                 input logic p, input logic s, output string tag);
    int ch;
    if (t != 16) begin tag = "R2"; return p; end
    if (!a_fsel) begin tag = a_ins ? "R5" : "R4"; return a_ins ? s : p; end
    if (f == 0) begin
      tag = "R6";
      case (b)
        4: return a_spare[2];
        5: return a_alarm;
        6: return a_spare[1];
        7: return a_spare[0];
        default: return 1'b0;
      endcase
    end
    ch = (b < 4) ? f : f + 16;
    if (a_mask[ch]) begin
      tag = (b < 4) ? "R7" : "R8";
      return a_tsig[ch*4 + 3 - (b % 4)];
    end
    tag = "R9";
    return a_ins ? s : p;
  endfunction

  // one full multiframe; optional config swap at frame chg_frm
  task automatic run_mf(input int chg_frm, input string chg_tag);
    logic  pend = 1'b0;
    logic  pexp = 1'b0;
    string ptag = "";
    for (int f = 0; f < 16; f++)
      for (int t = 0; t < 32; t++)
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          if (pend) check(ptag, tx_out, pexp);
          if (f == chg_frm && t == 0 && b == 0) begin
            blk_fsel = 1'b1; blk_mask = 32'hFFFF_FFFF; tsig_regs = make_tsig(8'h99);
          end
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          frm_idx = 4'(f); ts_idx = 5'(t); bit_idx = 3'(b);
          pcm_in = lfsr[0]; sig_in = lfsr[5]; bit_en = 1'b1;
          if (f == 0 && t == 0 && b == 0) begin
            a_ins = hw_ins_en; a_fsel = blk_fsel; a_mask = blk_mask;
            a_tsig = tsig_regs; a_alarm = mf_alarm; a_spare = spare_bits;
          end
          pexp = model(f, t, b, pcm_in, sig_in, ptag);
          if (chg_frm >= 0 && f >= chg_frm && t == 16) ptag = chg_tag;
          pend = 1'b1;
        end
    @(negedge clk);
    check(ptag, tx_out, pexp);
    bit_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; frm_idx = '0; ts_idx = '0; bit_idx = '0;
    pcm_in = 1'b1; sig_in = 1'b1; hw_ins_en = 1'b1; blk_fsel = 1'b1;
    blk_mask = '1; tsig_regs = '1; mf_alarm = 1'b1; spare_bits = '1;
    repeat (3) @(negedge clk);
    check("R1", tx_out, 1'b0);
    rst_n = 1'b1;

    // R1: configuration cleared to pass-through: ts16 of frame 0 follows pcm
    @(negedge clk);
    frm_idx = 4'd0; ts_idx = 5'd16; bit_idx = 3'd0; pcm_in = 1'b1; sig_in = 1'b0; bit_en = 1'b1;
    @(negedge clk);
    check("R1", tx_out, 1'b1);
    bit_en = 1'b0;

    // R3: no bit_en, input toggling, output holds
    for (int k = 0; k < 6; k++) begin
      ts_idx = 5'(k); pcm_in = k[0]; sig_in = ~k[0];
      @(negedge clk);
      check("R3", tx_out, 1'b1);
    end

    // table of configurations, one multiframe each
    foreach (ROWS[i]) begin
      {hw_ins_en, blk_fsel, blk_mask, mf_alarm, spare_bits} = ROWS[i][45:8];
      tsig_regs = make_tsig(ROWS[i][7:0]);
      run_mf(-1, "");
    end

    // R10: change settings at frame 3; old settings must stay in force
    hw_ins_en = 1'b0; blk_fsel = 1'b0; blk_mask = '0; mf_alarm = 1'b1; spare_bits = 3'b110;
    run_mf(3, "R10");
    // R10: next multiframe picks up the new settings (R6/R7/R8 octets)
    run_mf(-1, "");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule